// File: doc/BRIEF.md
# Interstage Gain Calibration Sequencer

This block is the digital controller that measures the interstage gain of a 1-bit first stage in a pipelined converter. While the analog input is held fixed by the surrounding system, the sequencer takes over the first-stage decision bit through the stage's multiplexer. In each measurement pair, it first drives the bit high and records one back-end code. It then drives the bit low and records a second code. The difference between the two codes grows with the stage gain multiplied by half the reference. That difference is the raw gain term.

One calibration runs a power-of-two number of pairs, set by a log2 repeat setting. It sums the signed pair differences in an accumulator that is wide enough that the sum cannot overflow. It then divides the sum by the pair count with an arithmetic right shift, which averages out back-end noise. The result is written into a coefficient register that holds its value until the next calibration ends. Back-end codes are trusted only after a fixed pipeline latency has elapsed since the forced bit last changed, and only in cycles where the back-end marks them valid.

Top module: `gcal_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `force_en`, `force_bit`, `busy` and `done` are low and `gain_coef` is zero.
- R2: A `start` pulse while idle raises `busy`. Every pair drives `force_bit`=1 first and then `force_bit`=0. `force_en` is high in every busy cycle except the `done` cycle and is low while idle.
- R3: A code is taken only in a cycle where `code_vld` is high and at least `LAT_CYC` cycles have passed since the cycle in which `force_bit` took its current value. Codes presented earlier, or with `code_vld` low, have no effect on the result.
- R4: The number of pairs is 2^`rep_log`. Settings above `MAX_LOG_REP` are treated as `MAX_LOG_REP`.
- R5: `code_in` is a two's-complement signed code. `gain_coef` is a signed (`CODE_W`+1)-bit value equal to floor(sum(code_hi - code_lo) / pair count), which rounds toward minus infinity for negative sums.
- R6: `done` is high for exactly one cycle at the end of a run, with `force_en` low in that cycle. The new `gain_coef` is visible from the next cycle, in which `busy` is low.
- R7: A `start` pulse while `busy` is high is ignored. The run in progress keeps its pair count and its result.
- R8: `gain_coef` changes only in the cycle right after `done`. While a later run is busy, it holds the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| rep_log | input | LOG_W (3) | log2 of the number of pairs, saturated at MAX_LOG_REP |
| code_in | input | CODE_W (10) | Signed back-end code |
| code_vld | input | 1 | Back-end code valid |
| force_en | output | 1 | Select the forced decision at the stage multiplexer |
| force_bit | output | 1 | Forced decision value |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| gain_coef | output | CODE_W+1 (11) | Stored averaged gain coefficient, signed |

## Verification
The bench models a back end that presents a poisoned code, with valid held high, during every latency window. A sequencer that samples one cycle early, or that ignores the latency count, would therefore produce a wildly wrong coefficient. Valid gaps after the window check that a code is not latched without `code_vld`. Runs with negative gain and odd sums expose a logical shift or truncation toward zero, and an oversized repeat setting exposes missing saturation through a wrong pair count. A second `start` in the middle of a run would restart the pair count or clear the sum if it were not ignored. The bench also reads the coefficient during a later run to catch a register that is written before `done`.

// File: rtl/gcal_pkg.sv
package gcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FORCE1 = 3'd1,
        ST_WAIT1  = 3'd2,
        ST_FORCE0 = 3'd3,
        ST_WAIT0  = 3'd4,
        ST_ACCUM  = 3'd5,
        ST_DONE   = 3'd6
    } gcal_state_e;

    typedef struct packed {
        logic cap_hi;
        logic cap_lo;
        logic acc_clr;
        logic acc_add;
        logic commit;
    } gcal_ctl_t;

    function automatic logic is_forcing(gcal_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

    function automatic logic is_high_phase(gcal_state_e s);
        return (s == ST_FORCE1) || (s == ST_WAIT1);
    endfunction

endpackage

// File: rtl/gcal_ctrl.sv
module gcal_ctrl
    import gcal_pkg::*;
#(
    parameter int LAT_CYC     = 3,
    parameter int MAX_LOG_REP = 4,
    parameter int LOG_W       = $clog2(MAX_LOG_REP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LOG_W-1:0] rep_log,
    input  logic             code_vld,
    output gcal_state_e      state,
    output logic [LOG_W-1:0] shift_amt,
    output gcal_ctl_t        ctl
);
    localparam int CNT_W  = (LAT_CYC > 1) ? $clog2(LAT_CYC) : 1;
    localparam int PAIR_W = MAX_LOG_REP + 1;
    localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(LAT_CYC - 1);

    gcal_state_e       st_q, st_d;
    logic [CNT_W-1:0]  lat_q, lat_d;
    logic [PAIR_W-1:0] pair_q, pair_d;
    logic [LOG_W-1:0]  sh_q, sh_d;
    logic [PAIR_W-1:0] last_pair;
    logic              lat_done;

    assign lat_done  = (lat_q == '0);
    assign last_pair = (PAIR_W'(1) << sh_q) - PAIR_W'(1);

    always_comb begin
        st_d   = st_q;
        lat_d  = lat_q;
        pair_d = pair_q;
        sh_d   = sh_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d   = ST_FORCE1;
                    pair_d = '0;
                    sh_d   = (rep_log > LOG_W'(MAX_LOG_REP)) ? LOG_W'(MAX_LOG_REP) : rep_log;
                end
            end
            ST_FORCE1: begin
                st_d  = ST_WAIT1;
                lat_d = LAT_LOAD;
            end
            ST_WAIT1: begin
                if (!lat_done)     lat_d = lat_q - CNT_W'(1);
                else if (code_vld) st_d  = ST_FORCE0;
            end
            ST_FORCE0: begin
                st_d  = ST_WAIT0;
                lat_d = LAT_LOAD;
            end
            ST_WAIT0: begin
                if (!lat_done)     lat_d = lat_q - CNT_W'(1);
                else if (code_vld) st_d  = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (pair_q == last_pair) st_d = ST_DONE;
                else begin
                    st_d   = ST_FORCE1;
                    pair_d = pair_q + PAIR_W'(1);
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            lat_q  <= '0;
            pair_q <= '0;
            sh_q   <= '0;
        end else begin
            st_q   <= st_d;
            lat_q  <= lat_d;
            pair_q <= pair_d;
            sh_q   <= sh_d;
        end
    end

    always_comb begin
        ctl         = '0;
        ctl.cap_hi  = (st_q == ST_WAIT1) && lat_done && code_vld;
        ctl.cap_lo  = (st_q == ST_WAIT0) && lat_done && code_vld;
        ctl.acc_clr = (st_q == ST_IDLE) && start;
        ctl.acc_add = (st_q == ST_ACCUM);
        ctl.commit  = (st_q == ST_DONE);
    end

    assign state     = st_q;
    assign shift_amt = sh_q;

endmodule

// File: rtl/gcal_datapath.sv
module gcal_datapath
    import gcal_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int ACC_W  = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  gcal_ctl_t                ctl,
    input  logic signed [CODE_W-1:0] code_in,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int DIFF_W = CODE_W + 1;
    localparam int NSLOT  = 2;

    logic signed [CODE_W-1:0] slot_q [NSLOT];
    logic                     slot_we [NSLOT];
    logic signed [DIFF_W-1:0] diff;
    logic signed [ACC_W-1:0]  acc_q;

    assign slot_we[0] = ctl.cap_hi;
    assign slot_we[1] = ctl.cap_lo;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)             slot_q[g] <= '0;
            else if (slot_we[g]) slot_q[g] <= code_in;
        end
    end

    assign diff = DIFF_W'(slot_q[0]) - DIFF_W'(slot_q[1]);

    always_ff @(posedge clk) begin
        if (rst)              acc_q <= '0;
        else if (ctl.acc_clr) acc_q <= '0;
        else if (ctl.acc_add) acc_q <= acc_q + ACC_W'(diff);
    end

    assign acc = acc_q;

endmodule

// File: rtl/gcal_coef.sv
module gcal_coef
    import gcal_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int ACC_W  = 15,
    parameter int LOG_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit,
    input  logic signed [ACC_W-1:0]  acc,
    input  logic [LOG_W-1:0]         shift_amt,
    output logic signed [CODE_W:0]   coef
);
    logic signed [ACC_W-1:0] avg;
    logic signed [CODE_W:0]  coef_q;

    assign avg = acc >>> shift_amt;

    always_ff @(posedge clk) begin
        if (rst)         coef_q <= '0;
        else if (commit) coef_q <= avg[CODE_W:0];
    end

    assign coef = coef_q;

endmodule

// File: rtl/gcal_seq.sv
module gcal_seq
    import gcal_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int LAT_CYC     = 3,
    parameter int MAX_LOG_REP = 4,
    parameter int LOG_W       = $clog2(MAX_LOG_REP + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [LOG_W-1:0]         rep_log,
    input  logic signed [CODE_W-1:0] code_in,
    input  logic                     code_vld,
    output logic                     force_en,
    output logic                     force_bit,
    output logic                     busy,
    output logic                     done,
    output logic signed [CODE_W:0]   gain_coef
);
    localparam int ACC_W = CODE_W + 1 + MAX_LOG_REP + 1;

    gcal_state_e             state;
    gcal_ctl_t               ctl;
    logic [LOG_W-1:0]        shift_amt;
    logic signed [ACC_W-1:0] acc;

    gcal_ctrl #(
        .LAT_CYC    (LAT_CYC),
        .MAX_LOG_REP(MAX_LOG_REP),
        .LOG_W      (LOG_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rep_log  (rep_log),
        .code_vld (code_vld),
        .state    (state),
        .shift_amt(shift_amt),
        .ctl      (ctl)
    );

    gcal_datapath #(
        .CODE_W(CODE_W),
        .ACC_W (ACC_W)
    ) dp_i (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .code_in(code_in),
        .acc    (acc)
    );

    gcal_coef #(
        .CODE_W(CODE_W),
        .ACC_W (ACC_W),
        .LOG_W (LOG_W)
    ) coef_i (
        .clk      (clk),
        .rst      (rst),
        .commit   (ctl.commit),
        .acc      (acc),
        .shift_amt(shift_amt),
        .coef     (gain_coef)
    );

    assign force_en  = is_forcing(state);
    assign force_bit = is_high_phase(state);
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/gcal_seq_chk.sv
module gcal_seq_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              force_en,
    input logic              force_bit,
    input logic              busy,
    input logic              done,
    input logic [CODE_W:0]   gain_coef
);
    assert_force_off_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !force_en);

    assert_first_phase_high_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (force_en && force_bit));

    assert_done_no_force_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !force_en);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_run_not_cut_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_coef_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(done) |-> $stable(gain_coef));

endmodule

bind gcal_seq gcal_seq_chk #(.CODE_W(CODE_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .force_en (force_en),
    .force_bit(force_bit),
    .busy     (busy),
    .done     (done),
    .gain_coef(gain_coef)
);

// File: tb/gcal_seq_tb_top.sv
module gcal_seq_tb_top;
    localparam int CODE_W  = 10;
    localparam int LAT_CYC = 3;
    localparam int MAXLOG  = 4;
    localparam int LOG_W   = 3;
    localparam int POISON  = -500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LOG_W-1:0] rep_log = '0;
    logic signed [CODE_W-1:0] code_in = '0;
    logic code_vld = 1'b0;
    logic force_en, force_bit, busy, done;
    logic signed [CODE_W:0] gain_coef;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    int cur_h = 0, cur_l = 0, cur_gap = 0;
    int rises = 0;
    int last_coef = 0;
    int exp_coef_q[$];
    int exp_pairs_q[$];

    always #10 clk = ~clk;

    gcal_seq #(.CODE_W(CODE_W), .LAT_CYC(LAT_CYC), .MAX_LOG_REP(MAXLOG)) dut_i (
        .clk(clk), .rst(rst), .start(start), .rep_log(rep_log),
        .code_in(code_in), .code_vld(code_vld),
        .force_en(force_en), .force_bit(force_bit), .busy(busy),
        .done(done), .gain_coef(gain_coef)
    );

    function automatic int noise(int p, int s);
        return ((p * 3 + s * 5) % 7) - 3;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // back-end model: poison inside the latency window, valid gap after it
    initial begin
        int k;
        logic prev;
        k = 0;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (force_bit != prev) begin
                k = 0;
                if (force_bit) rises++;
            end else k++;
            prev = force_bit;
            if (!force_en) begin
                code_vld = 1'b1;
                code_in  = CODE_W'(POISON);
            end else if (k < LAT_CYC) begin
                code_vld = 1'b1;
                code_in  = CODE_W'(POISON);
            end else if (k < LAT_CYC + cur_gap) begin
                code_vld = 1'b0;
                code_in  = CODE_W'(POISON + 7);
            end else begin
                code_vld = 1'b1;
                code_in  = force_bit ? CODE_W'(cur_h + noise(rises - 1, 1))
                                     : CODE_W'(cur_l + noise(rises - 1, 0));
            end
        end
    end

    // monitor: pop expected results when a run ends
    initial begin
        int e, np;
        forever begin
            @(negedge clk);
            if (done) begin
                check("R6 force_en low at done", int'(force_en), 0);
                np = exp_pairs_q.pop_front();
                check("R4 pair count", rises, np);
                e = exp_coef_q.pop_front();
                check("R8 coef not early", int'(gain_coef), last_coef);
                @(negedge clk);
                check("R5 coefficient", int'(gain_coef), e);
                check("R6 idle after done", int'(busy), 0);
                last_coef = e;
            end
        end
    end

    task automatic run_cal(int lg, int h, int l, int gap, bit poke);
        int n, sum, sh;
        sh  = (lg > MAXLOG) ? MAXLOG : lg;
        n   = 1 << sh;
        sum = 0;
        for (int p = 0; p < n; p++)
            sum += (h + noise(p, 1)) - (l + noise(p, 0));
        exp_coef_q.push_back(sum >>> sh);
        exp_pairs_q.push_back(n);
        cur_h = h; cur_l = l; cur_gap = gap;
        @(negedge clk);
        rises = 0;
        rep_log = LOG_W'(lg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        check("R2 first phase forced high", int'(force_en && force_bit), 1);
        if (poke) begin
            repeat (9) @(negedge clk);
            check("R8 coef held during run", int'(gain_coef), last_coef);
            start = 1'b1;
            rep_log = '0;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2 force_en low idle", int'(force_en), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog: actual %0d expected <100000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 force_en", int'(force_en), 0);
        check("R1 force_bit", int'(force_bit), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 coef", int'(gain_coef), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", int'(busy || force_en || done), 0);
        check("R1 coef after reset", int'(gain_coef), 0);

        run_cal(0, 200, -180, 0, 1'b0);   // single pair, R3 poison window
        run_cal(2, 150, -100, 2, 1'b0);   // valid gaps, R3
        run_cal(1, -120, 95, 1, 1'b0);    // negative gain, R5 floor
        run_cal(4, 60, 57, 0, 1'b1);      // restart ignored R7, hold R8
        run_cal(7, 300, -200, 1, 1'b0);   // saturation R4
        run_cal(3, -7, 0, 0, 1'b0);       // small negative odd sum R5

        repeat (5) @(negedge clk);
        check("R8 coef held when idle", int'(gain_coef), last_coef);
        check("R4 all results consumed", exp_coef_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule